// File: doc/BRIEF.md
# Per-Rank DRAM Refresh Scheduler

This block keeps a separate refresh schedule for each of eight DRAM chip-select ranks. It issues one refresh command at a time onto a shared command bus. Software sets a refresh interval in clock cycles, a recovery time in cycles, and a mask of the ranks that hold memory. Each populated rank runs its own interval timer. Every time the timer expires, the rank owes one more refresh. A rank that owes a refresh asks for the bus. The request is granted only when the command bus is free and the memory controller reports no outstanding access to that rank. Accesses to other ranks therefore continue while a refresh runs.

Each rank is a small state machine with four states. `RK_OFF` is an unpopulated rank. `RK_WAIT` means the rank is counting and owes nothing. `RK_OWED` means at least one refresh is owed and the rank is requesting. `RK_LOCK` is the recovery window after a refresh. The transitions are:
- populate: `RK_OFF` to `RK_WAIT`, which loads the timer.
- expire: `RK_WAIT` to `RK_OWED`.
- grant: `RK_OWED` to `RK_LOCK`, which loads the recovery count.
- recover: `RK_LOCK` back to `RK_OWED` if debt remains, otherwise to `RK_WAIT`.
- depopulate: any state to `RK_OFF`, which clears the debt.

A round-robin arbiter picks one requesting rank per cycle. It drives a registered one-cycle strobe with a one-hot chip-select vector.

Top module: `rank_refresh_sched`

## Requirements
- R1: While reset is asserted and just after it, `ref_strobe_o` is 0, and `ref_cs_o`, `ref_locked_o` and `urgent_o` are all zero.
- R2: With interval N, bus free and no busy bit, a rank populated at reset release gets its first strobe in the (N+2)th cycle after release. Later strobes to that rank follow every N cycles.
- R3: A rank whose `populated_i` bit is 0 never receives a strobe, however much debt it had.
- R4: `ref_strobe_o` lasts one cycle per refresh. While it is high, `ref_cs_o` has exactly one bit set, and bit i selects rank i. While it is low, `ref_cs_o` is zero.
- R5: A grant is made only at an edge where `cmd_free_i` is high. The strobe appears in the cycle after that edge. While the bus stays busy, the owed refreshes wait.
- R6: A rank whose `busy_i` bit is set is not refreshed. Other ranks are refreshed meanwhile. The deferred refresh is issued in the cycle after the bit clears.
- R7: When several ranks request at once, ranks are served one per cycle, in index order, starting after the rank granted last. After reset the search starts at rank 0.
- R8: After a refresh, `ref_locked_o` of that rank is high for R cycles, starting with the strobe cycle, where R is `recover_i` (at least 1). The rank gets no grant while locked. A rank that still owes refreshes is strobed again R+1 cycles after its previous strobe.
- R9: Each timer expiry adds one owed refresh and each grant removes one. The debt saturates at 8. `urgent_o` of a rank is high exactly while it owes 8.
- R10: Clearing a rank's `populated_i` bit clears its debt, and `urgent_o` drops in the next cycle. Repopulating it restarts its schedule as in R2.
- R11: A new `interval_i` value takes effect at the rank's next timer reload, which happens on expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| interval_i | input | IW (16) | Refresh interval in cycles |
| recover_i | input | RW (8) | Recovery lock time in cycles |
| populated_i | input | NR (8) | Rank population mask |
| busy_i | input | NR (8) | Ranks with outstanding reads or writes |
| cmd_free_i | input | 1 | Shared command bus is free this cycle |
| ref_strobe_o | output | 1 | One-cycle refresh command strobe |
| ref_cs_o | output | NR (8) | One-hot rank select for the refresh |
| ref_locked_o | output | NR (8) | Rank is in refresh recovery |
| urgent_o | output | NR (8) | Rank has reached the debt limit |

## Verification
A timer expiry at edge E makes the rank request in the next cycle. The grant and the registered strobe then take effect at edge E+1, which puts the first strobe at N+2 cycles after reset release. A released `busy_i` or `cmd_free_i` gives a strobe one edge later. `ref_locked_o` rises with the strobe, and `urgent_o` changes at the same edge as the expiry or grant that moves the debt across 8. The bench drives inputs and reads outputs 1 ns after each rising edge and numbers the edges from reset release. Every expected value is placed at an edge number worked out from these latencies.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [1:0] {
        RK_OFF  = 2'd0,
        RK_WAIT = 2'd1,
        RK_OWED = 2'd2,
        RK_LOCK = 2'd3
    } rank_state_t;

endpackage

// File: rtl/refsch_rank.sv
module refsch_rank
    import refsch_pkg::*;
#(
    parameter int IW       = 16,
    parameter int RW       = 8,
    parameter int MAX_OWED = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval_i,
    input  logic [RW-1:0] recover_i,
    input  logic          populated_i,
    input  logic          busy_i,
    input  logic          grant_i,
    output logic          req_o,
    output logic          locked_o,
    output logic          urgent_o
);

    localparam int            OW       = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] OWED_CAP = OW'(MAX_OWED);

    rank_state_t   state_q, state_d;
    logic [IW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] lock_q, lock_d;
    logic [OW-1:0] owed_q, owed_d;
    logic          expire;

    assign expire = (state_q != RK_OFF) && (cnt_q <= IW'(1));

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lock_d  = lock_q;
        owed_d  = owed_q;
        if (state_q != RK_OFF) begin
            if (expire) cnt_d = interval_i;
            else        cnt_d = cnt_q - 1'b1;
            if (expire && owed_q != OWED_CAP) owed_d = owed_q + 1'b1;
            if (grant_i) owed_d = owed_d - 1'b1;
        end
        unique case (state_q)
            RK_OFF: begin
                if (populated_i) begin
                    state_d = RK_WAIT;
                    cnt_d   = interval_i;
                    owed_d  = '0;
                end
            end
            RK_WAIT: begin
                if (expire) state_d = RK_OWED;
            end
            RK_OWED: begin
                if (grant_i) begin
                    state_d = RK_LOCK;
                    lock_d  = recover_i;
                end
            end
            RK_LOCK: begin
                if (lock_q <= RW'(1)) state_d = (owed_d != '0) ? RK_OWED : RK_WAIT;
                else                  lock_d  = lock_q - 1'b1;
            end
        endcase
        if (!populated_i) begin
            state_d = RK_OFF;
            cnt_d   = '0;
            lock_d  = '0;
            owed_d  = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RK_OFF;
            cnt_q   <= '0;
            lock_q  <= '0;
            owed_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lock_q  <= lock_d;
            owed_q  <= owed_d;
        end
    end

    // outputs
    always_comb begin
        req_o    = (state_q == RK_OWED) && populated_i && !busy_i;
        locked_o = (state_q == RK_LOCK);
        urgent_o = (owed_q == OWED_CAP);
    end

    AST_LOCK_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RK_LOCK) |-> !grant_i);                       // R8
    AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RK_OFF) |-> !grant_i);                        // R3
    AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= OWED_CAP);                                      // R9
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !populated_i |=> (owed_q == '0));                         // R10

endmodule

// File: rtl/refsch_rr_arb.sv
module refsch_rr_arb #(
    parameter int NR = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NR-1:0] req_i,
    output logic [NR-1:0] grant_o,
    output logic          strobe_o,
    output logic [NR-1:0] cs_o
);

    localparam int IXW = (NR > 1) ? $clog2(NR) : 1;

    logic [IXW-1:0] last_q;
    logic [IXW-1:0] win;
    logic           hit;

    always_comb begin
        grant_o = '0;
        hit     = 1'b0;
        win     = last_q;
        for (int i = 1; i <= NR; i++) begin
            int idx;
            idx = (int'(last_q) + i) % NR;
            if (!hit && req_i[idx]) begin
                grant_o[idx] = 1'b1;
                hit          = 1'b1;
                win          = IXW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q   <= IXW'(NR - 1);
            strobe_o <= 1'b0;
            cs_o     <= '0;
        end else begin
            strobe_o <= hit;
            cs_o     <= grant_o;
            if (hit) last_q <= win;
        end
    end

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));                                       // R7
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);                                // R7

endmodule

// File: rtl/rank_refresh_sched.sv
module rank_refresh_sched #(
    parameter int NR       = 8,
    parameter int IW       = 16,
    parameter int RW       = 8,
    parameter int MAX_OWED = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval_i,
    input  logic [RW-1:0] recover_i,
    input  logic [NR-1:0] populated_i,
    input  logic [NR-1:0] busy_i,
    input  logic          cmd_free_i,
    output logic          ref_strobe_o,
    output logic [NR-1:0] ref_cs_o,
    output logic [NR-1:0] ref_locked_o,
    output logic [NR-1:0] urgent_o
);

    logic [NR-1:0] rank_req;
    logic [NR-1:0] arb_req;
    logic [NR-1:0] grant;

    for (genvar g = 0; g < NR; g++) begin : g_rank
        refsch_rank #(
            .IW       (IW),
            .RW       (RW),
            .MAX_OWED (MAX_OWED)
        ) u_rank (
            .clk         (clk),
            .rst_n       (rst_n),
            .interval_i  (interval_i),
            .recover_i   (recover_i),
            .populated_i (populated_i[g]),
            .busy_i      (busy_i[g]),
            .grant_i     (grant[g]),
            .req_o       (rank_req[g]),
            .locked_o    (ref_locked_o[g]),
            .urgent_o    (urgent_o[g])
        );
    end

    assign arb_req = rank_req & {NR{cmd_free_i}};

    refsch_rr_arb #(.NR(NR)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (arb_req),
        .grant_o  (grant),
        .strobe_o (ref_strobe_o),
        .cs_o     (ref_cs_o)
    );

    AST_STROBE_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe_o |-> ($countones(ref_cs_o) == 1));           // R4
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_strobe_o |-> (ref_cs_o == '0));                      // R4
    AST_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe_o |-> $past(cmd_free_i));                      // R5
    AST_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe_o |-> ((ref_cs_o & $past(busy_i)) == '0));    // R6
    AST_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe_o |-> ((ref_cs_o & ~$past(populated_i)) == '0)); // R3

endmodule

// File: tb/rank_refresh_sched_tb.sv
`timescale 1ns/100ps
module rank_refresh_sched_tb;

    localparam int NR = 8;
    localparam int IW = 16;
    localparam int RW = 8;

    // table: interval, recovery, rank, expected tick of first strobe (N+2)
    localparam int NV = 4;
    localparam int VEC_N    [NV] = '{6, 9, 12, 20};
    localparam int VEC_R    [NV] = '{1, 2, 3, 5};
    localparam int VEC_RK   [NV] = '{0, 3, 5, 7};
    localparam int VEC_FIRST[NV] = '{8, 11, 14, 22};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] interval = '0;
    logic [RW-1:0] recov = '0;
    logic [NR-1:0] pop = '0;
    logic [NR-1:0] busy = '0;
    logic          cmd_free = 1'b0;
    logic          ref_strobe_o;
    logic [NR-1:0] ref_cs_o;
    logic [NR-1:0] ref_locked_o;
    logic [NR-1:0] urgent_o;

    int n_cmp = 0;
    int n_bad = 0;
    int tk = 0;
    int n_strobe = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rank_refresh_sched #(.NR(NR), .IW(IW), .RW(RW), .MAX_OWED(8)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .interval_i   (interval),
        .recover_i    (recov),
        .populated_i  (pop),
        .busy_i       (busy),
        .cmd_free_i   (cmd_free),
        .ref_strobe_o (ref_strobe_o),
        .ref_cs_o     (ref_cs_o),
        .ref_locked_o (ref_locked_o),
        .urgent_o     (urgent_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at tick %0d: actual=%0d expected=%0d", tag, tk, act, exp);
        end
    endtask

    // one edge; outputs read 1 ns later; strobes monitored for R3 and R4
    task automatic tick();
        @(posedge clk);
        #1;
        tk++;
        if (ref_strobe_o) begin
            n_strobe++;
            chk("R4 one-hot cs", $countones(ref_cs_o), 1);
            chk("R3 cs within population", int'(ref_cs_o & ~pop), 0);
        end else begin
            chk("R4 cs idle", int'(ref_cs_o), 0);
        end
    endtask

    task automatic tick_to(input int t);
        while (tk < t) tick();
    endtask

    task automatic wait_strobe(input int limit, output int at);
        int n;
        at = -1;
        n  = 0;
        while (at < 0 && n < limit) begin
            tick();
            n++;
            if (ref_strobe_o) at = tk;
        end
    endtask

    task automatic do_reset(input logic [NR-1:0] m, input int n, input int r,
                            input logic fr, input logic [NR-1:0] bz);
        rst_n    = 1'b0;
        pop      = m;
        interval = IW'(n);
        recov    = RW'(r);
        cmd_free = fr;
        busy     = bz;
        repeat (2) @(posedge clk);
        #1;
        rst_n    = 1'b1;
        tk       = 0;
        n_strobe = 0;
    endtask

    initial begin
        int at, at2, lc, base;
        int ord [8];

        // vector table: first strobe time, cs, lock length, period
        for (int v = 0; v < NV; v++) begin
            do_reset(NR'(1) << VEC_RK[v], VEC_N[v], VEC_R[v], 1'b1, '0);
            chk("R1 strobe in reset", int'(ref_strobe_o), 0);
            chk("R1 cs in reset", int'(ref_cs_o), 0);
            chk("R1 locked in reset", int'(ref_locked_o), 0);
            chk("R1 urgent in reset", int'(urgent_o), 0);
            wait_strobe(100, at);
            chk("R2 first strobe tick", at, VEC_FIRST[v]);
            chk("R2 cs of rank", int'(ref_cs_o), 1 << VEC_RK[v]);
            lc = 0;
            while (ref_locked_o[VEC_RK[v]] && lc < 50) begin
                lc++;
                tick();
            end
            chk("R8 lock length", lc, VEC_R[v]);
            wait_strobe(100, at2);
            chk("R2 period", at2 - at, VEC_N[v]);
        end

        // R5: bus held busy, then released
        do_reset(8'h04, 6, 2, 1'b0, '0);
        tick_to(15);
        chk("R5 no strobe while bus busy", n_strobe, 0);
        cmd_free = 1'b1;
        tick();
        chk("R5 strobe after bus free", int'(ref_strobe_o), 1);
        chk("R5 cs", int'(ref_cs_o), 8'h04);
        tick();
        chk("R8 locked no strobe", int'(ref_strobe_o), 0);
        tick();
        chk("R8 locked no strobe", int'(ref_strobe_o), 0);
        tick();
        chk("R8 owed strobe spacing R+1", int'(ref_strobe_o), 1);

        // R6: busy rank deferred, neighbour proceeds
        do_reset(8'h0C, 8, 1, 1'b1, 8'h04);
        tick_to(10);
        chk("R6 other rank refreshed", int'(ref_cs_o), 8'h08);
        tick_to(14);
        chk("R6 busy rank deferred", n_strobe, 1);
        busy = '0;
        tick();
        chk("R6 deferred strobe", int'(ref_strobe_o), 1);
        chk("R6 deferred cs", int'(ref_cs_o), 8'h04);

        // R7: round robin across all ranks
        do_reset(8'hFF, 12, 3, 1'b1, '0);
        tick_to(13);
        chk("R7 none before expiry", n_strobe, 0);
        for (int r = 0; r < 8; r++) begin
            tick();
            chk("R7 order round 1", int'(ref_cs_o), 1 << r);
        end
        tick_to(24);
        busy = 8'h07;
        tick_to(25);
        ord = '{3, 4, 5, 6, 7, 0, 1, 2};
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R7 rotated order", int'(ref_cs_o), 1 << ord[i]);
            if (tk == 27) busy = '0;
        end

        // R9: debt accumulation, urgent and saturation
        do_reset(8'h02, 4, 2, 1'b0, '0);
        tick_to(32);
        chk("R9 not urgent at 7 owed", int'(urgent_o), 0);
        tick();
        chk("R9 urgent at 8 owed", int'(urgent_o), 8'h02);
        tick_to(42);
        chk("R9 urgent saturated", int'(urgent_o), 8'h02);
        chk("R5 nothing issued", n_strobe, 0);
        cmd_free = 1'b1;
        tick();
        chk("R9 strobe on release", int'(ref_strobe_o), 1);
        chk("R9 urgent drops after grant", int'(urgent_o), 0);
        tick();
        chk("R8 locked cycle 2", int'(ref_locked_o), 8'h02);
        tick();
        chk("R8 lock over", int'(ref_locked_o), 0);
        chk("R8 no strobe", int'(ref_strobe_o), 0);
        tick();
        chk("R8 next owed strobe", int'(ref_strobe_o), 1);

        // R10: depopulation clears debt, repopulation restarts
        do_reset(8'h02, 2, 1, 1'b0, '0);
        tick_to(16);
        chk("R9 not urgent", int'(urgent_o), 0);
        tick();
        chk("R9 urgent", int'(urgent_o), 8'h02);
        tick_to(20);
        pop = '0;
        cmd_free = 1'b1;
        tick();
        chk("R10 urgent cleared", int'(urgent_o), 0);
        chk("R10 not locked", int'(ref_locked_o), 0);
        base = n_strobe;
        tick_to(25);
        chk("R3 empty rank not refreshed", n_strobe - base, 0);
        pop = 8'h02;
        wait_strobe(20, at);
        chk("R10 restart first strobe", at, 29);

        // R11: interval change applies at next reload
        do_reset(8'h01, 10, 2, 1'b1, '0);
        wait_strobe(50, at);
        chk("R2 first strobe", at, 12);
        interval = IW'(5);
        wait_strobe(50, at);
        chk("R11 old interval still running", at, 22);
        wait_strobe(50, at);
        chk("R11 new interval", at, 27);

        summary();
        $finish;
    end

endmodule